// File: doc/BRIEF.md
# DMA Channel Register Bank with Start Detection

This block holds the software-visible setup registers for up to seven DMA channels and one global control word. The 7-bit register offset is split into a group number and a register index. Each channel group has three registers: a base address, a block register and a control register. The top group holds the global control word and a window onto an interrupt register. That interrupt register lives outside this block and is reached through a write strobe and a read-data input.

On every accepted write to a channel register, the block looks at that channel's control word as it stands after the write. If the channel is armed, the block emits a one-cycle start pulse. The pulse carries the channel index and the effective sync mode, and a transfer engine downstream acts on it.

A read or a write to an offset that maps to no register raises a one-cycle error strobe. A read of such an offset returns zero.

Top module: `dma_regbank`

## Requirements
- R1: Offset bits 6:4 select the group and bits 3:0 select the register. Groups 0 to 6 are channels, with index 0 for the base address, 4 for the block register and 8 for the control register. Read data appears on `rdata_o` on the clock edge that accepts the read, and channels keep independent contents.
- R2: A base address write stores only the low 24 bits, and bits 31:24 read back as zero.
- R3: The block register stores all 32 bits: the block size in bits 15:0 and the block count in bits 31:16.
- R4: The control register keeps only these fields, and every other bit reads back as zero (mask 0x11770703):
  - bit 0: direction
  - bit 1: address step
  - bit 8: chopping enable
  - bits 10:9: sync mode
  - bits 18:16: DMA chop window
  - bits 22:20: CPU chop window
  - bit 24: enable
  - bit 28: trigger
- R5: Group 7 index 0 is a 32-bit global control word that reads back exactly as written.
- R6: Group 7 index 4 is the external interrupt register. A write to it gives a one-cycle `irq_wr_o` pulse with the written word on `irq_wdata_o`. A read of it returns `irq_rd_i`.
- R7: After a channel write, a one-cycle `start_o` pulse follows on the next edge, with `start_chan_o` set to that channel, when control bit 24 is set and the sync mode is request (1) or linked list (2).
- R8: In manual sync mode (0) a start also requires control bit 28. With enable set and bit 28 clear, no start occurs.
- R9: `start_mode_o` reports the sync mode as 0, 1 or 2. A stored encoding of 3 is reported as request (1) and starts like request mode.
- R10: An unmapped offset gives a one-cycle `err_o` pulse. A read of it returns zero, and a write to it changes no register and raises neither `start_o` nor `irq_wr_o`.
- R11: Reset clears every register to zero, and `start_o`, `err_o` and `irq_wr_o` stay low out of reset.
- R12: A write to the base or block register of a channel whose stored control is armed also starts that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write request |
| rd_en_i | input | 1 | Register read request |
| addr_i | input | 7 | Register offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | Unmapped-offset strobe |
| start_o | output | 1 | Channel start pulse |
| start_chan_o | output | 3 | Index of the started channel |
| start_mode_o | output | 2 | Effective sync mode of the started channel |
| irq_wr_o | output | 1 | Interrupt register write strobe |
| irq_wdata_o | output | 32 | Interrupt register write data |
| irq_rd_i | input | 32 | Interrupt register read value |

## Verification
The bench builds the block with its default parameters: seven channels, a 7-bit offset and a 24-bit base field. With these values every group number from 0 to 7 is reachable, so random offsets hit all seven channels, the global group and unmapped indices in every group. Random control words reach all four sync-mode encodings with the enable and trigger bits in every combination. Directed cases pin down the manual-trigger gate, the folding of encoding 3, starts caused by writes to base and block, and the masking of reserved bits.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;

  localparam logic [31:0] CTRL_KEEP = 32'h1177_0703;
  localparam int          EN_BIT    = 24;
  localparam int          TRIG_BIT  = 28;
  localparam int          MODE_LSB  = 9;

  typedef enum logic [1:0] {
    SYNC_MANUAL = 2'd0,
    SYNC_REQ    = 2'd1,
    SYNC_LIST   = 2'd2,
    SYNC_SPARE  = 2'd3
  } sync_e;

  typedef enum logic [2:0] {
    K_BASE  = 3'd0,
    K_BLOCK = 3'd1,
    K_CTRL  = 3'd2,
    K_GCTL  = 3'd3,
    K_IRQ   = 3'd4,
    K_BAD   = 3'd5
  } kind_e;

  function automatic sync_e eff_mode(input logic [1:0] raw);
    return (raw == 2'd3) ? SYNC_REQ : sync_e'(raw);
  endfunction

endpackage

// File: rtl/dma_addr_decode.sv
module dma_addr_decode import dma_regbank_pkg::*; #(
  parameter int NUM_CH = 7,
  parameter int ADDR_W = 7,
  parameter int IDX_W  = 4,
  parameter int CH_W   = ADDR_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CH_W-1:0]   grp,
  output kind_e             kind
);
  localparam logic [CH_W-1:0] GLOBAL_GRP = '1;

  logic [IDX_W-1:0] idx;

  assign grp = addr[ADDR_W-1:IDX_W];
  assign idx = addr[IDX_W-1:0];

  always_comb begin
    kind = K_BAD;
    if (32'(grp) < NUM_CH) begin
      case (idx)
        IDX_W'(0): kind = K_BASE;
        IDX_W'(4): kind = K_BLOCK;
        IDX_W'(8): kind = K_CTRL;
        default:   kind = K_BAD;
      endcase
    end else if (grp == GLOBAL_GRP) begin
      case (idx)
        IDX_W'(0): kind = K_GCTL;
        IDX_W'(4): kind = K_IRQ;
        default:   kind = K_BAD;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_bank.sv
module dma_chan_bank import dma_regbank_pkg::*; #(
  parameter int NUM_CH = 7,
  parameter int CH_W   = 3,
  parameter int DATA_W = 32,
  parameter int BASE_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CH_W-1:0]   chan,
  input  kind_e             kind,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] ctl_cur
);
  localparam logic [DATA_W-1:0] KEEP = DATA_W'(CTRL_KEEP);

  logic [BASE_W-1:0] base_a [NUM_CH];
  logic [DATA_W-1:0] blk_a  [NUM_CH];
  logic [DATA_W-1:0] ctl_a  [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [BASE_W-1:0] base_r;
    logic [DATA_W-1:0] blk_r;
    logic [DATA_W-1:0] ctl_r;
    logic              hit;

    assign hit = we && (chan == CH_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_r <= '0;
        blk_r  <= '0;
        ctl_r  <= '0;
      end else if (hit) begin
        case (kind)
          K_BASE:  base_r <= wdata[BASE_W-1:0];
          K_BLOCK: blk_r  <= wdata;
          K_CTRL:  ctl_r  <= wdata & KEEP;
          default: ;
        endcase
      end
    end

    assign base_a[g] = base_r;
    assign blk_a[g]  = blk_r;
    assign ctl_a[g]  = ctl_r;
  end

  always_comb begin
    logic [BASE_W-1:0] b;
    logic [DATA_W-1:0] k;
    b       = '0;
    k       = '0;
    ctl_cur = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chan == CH_W'(i)) begin
        b       = base_a[i];
        k       = blk_a[i];
        ctl_cur = ctl_a[i];
      end
    end
    case (kind)
      K_BASE:  rd_word = DATA_W'(b);
      K_BLOCK: rd_word = k;
      K_CTRL:  rd_word = ctl_cur;
      default: rd_word = '0;
    endcase
  end
endmodule

// File: rtl/dma_start_detect.sv
module dma_start_detect import dma_regbank_pkg::*; #(
  parameter int CH_W   = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [CH_W-1:0]   chan,
  input  logic [DATA_W-1:0] ctl_next,
  output logic              start_o,
  output logic [CH_W-1:0]   start_chan_o,
  output logic [1:0]        start_mode_o
);
  logic [1:0] raw_mode;
  logic       armed;

  assign raw_mode = ctl_next[MODE_LSB+1:MODE_LSB];
  assign armed    = ctl_next[EN_BIT] &&
                    ((raw_mode != SYNC_MANUAL) || ctl_next[TRIG_BIT]);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_o      <= 1'b0;
      start_chan_o <= '0;
      start_mode_o <= '0;
    end else begin
      start_o <= fire && armed;
      if (fire && armed) begin
        start_chan_o <= chan;
        start_mode_o <= eff_mode(raw_mode);
      end
    end
  end
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank import dma_regbank_pkg::*; #(
  parameter  int NUM_CH = 7,
  parameter  int ADDR_W = 7,
  parameter  int IDX_W  = 4,
  parameter  int DATA_W = 32,
  parameter  int BASE_W = 24,
  localparam int CH_W   = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              start_o,
  output logic [CH_W-1:0]   start_chan_o,
  output logic [1:0]        start_mode_o,
  output logic              irq_wr_o,
  output logic [DATA_W-1:0] irq_wdata_o,
  input  logic [DATA_W-1:0] irq_rd_i
);
  localparam logic [DATA_W-1:0] KEEP = DATA_W'(CTRL_KEEP);

  logic [CH_W-1:0]   grp;
  kind_e             kind;
  logic              chan_reg;
  logic              chan_wr;
  logic [DATA_W-1:0] bank_rd;
  logic [DATA_W-1:0] ctl_cur;
  logic [DATA_W-1:0] ctl_next;
  logic [DATA_W-1:0] gctl_q;
  logic [DATA_W-1:0] rd_mux;

  dma_addr_decode #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CH_W(CH_W)
  ) u_dec (
    .addr(addr_i), .grp(grp), .kind(kind)
  );

  assign chan_reg = (kind == K_BASE) || (kind == K_BLOCK) || (kind == K_CTRL);
  assign chan_wr  = wr_en_i && chan_reg;

  dma_chan_bank #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W), .BASE_W(BASE_W)
  ) u_bank (
    .clk(clk), .rst(rst), .we(chan_wr), .chan(grp), .kind(kind),
    .wdata(wdata_i), .rd_word(bank_rd), .ctl_cur(ctl_cur)
  );

  assign ctl_next = (kind == K_CTRL) ? (wdata_i & KEEP) : ctl_cur;

  dma_start_detect #(
    .CH_W(CH_W), .DATA_W(DATA_W)
  ) u_start (
    .clk(clk), .rst(rst), .fire(chan_wr), .chan(grp), .ctl_next(ctl_next),
    .start_o(start_o), .start_chan_o(start_chan_o), .start_mode_o(start_mode_o)
  );

  always_comb begin
    case (kind)
      K_BASE, K_BLOCK, K_CTRL: rd_mux = bank_rd;
      K_GCTL:                  rd_mux = gctl_q;
      K_IRQ:                   rd_mux = irq_rd_i;
      default:                 rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gctl_q      <= '0;
      rdata_o     <= '0;
      err_o       <= 1'b0;
      irq_wr_o    <= 1'b0;
      irq_wdata_o <= '0;
    end else begin
      err_o    <= (wr_en_i || rd_en_i) && (kind == K_BAD);
      irq_wr_o <= wr_en_i && (kind == K_IRQ);
      if (wr_en_i && (kind == K_IRQ)) irq_wdata_o <= wdata_i;
      if (wr_en_i && (kind == K_GCTL)) gctl_q <= wdata_i;
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk #(
  parameter int NUM_CH = 7,
  parameter int CH_W   = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o,
  input logic              start_o,
  input logic [CH_W-1:0]   start_chan_o,
  input logic [1:0]        start_mode_o,
  input logic              irq_wr_o
);
  // R7
  start_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |-> $past(wr_en_i));
  // R7
  start_chan_range_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (32'(start_chan_o) < NUM_CH));
  // R9
  start_mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (start_mode_o != 2'd3));
  // R10
  err_has_access_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(wr_en_i || rd_en_i));
  // R10
  err_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (err_o && $past(rd_en_i)) |-> (rdata_o == '0));
  // R6
  irq_strobe_from_write_chk: assert property (@(posedge clk) disable iff (rst)
    irq_wr_o |-> $past(wr_en_i));
  // R11
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!start_o && !err_o && !irq_wr_o));
endmodule

bind dma_regbank dma_regbank_chk #(
  .NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .rdata_o(rdata_o), .err_o(err_o), .start_o(start_o),
  .start_chan_o(start_chan_o), .start_mode_o(start_mode_o),
  .irq_wr_o(irq_wr_o)
);

// File: tb/test_dma_regbank.sv
`timescale 1ns/1ps
module test_dma_regbank;
  localparam int NCH = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [6:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        err_o;
  logic        start_o;
  logic [2:0]  start_chan_o;
  logic [1:0]  start_mode_o;
  logic        irq_wr_o;
  logic [31:0] irq_wdata_o;
  logic [31:0] irq_rd_i = '0;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_base [NCH];
  logic [31:0] m_blk  [NCH];
  logic [31:0] m_ctl  [NCH];
  logic [31:0] m_gctl;

  always #5 clk = ~clk;

  dma_regbank i_dma_regbank (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o),
    .start_o(start_o), .start_chan_o(start_chan_o),
    .start_mode_o(start_mode_o), .irq_wr_o(irq_wr_o),
    .irq_wdata_o(irq_wdata_o), .irq_rd_i(irq_rd_i)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // 0 base, 1 block, 2 ctrl, 3 global ctrl, 4 irq, 5 unmapped
  function automatic int kind_of(input logic [6:0] a);
    if (a[6:4] < 3'd7) begin
      if (a[3:0] == 4'd0) return 0;
      if (a[3:0] == 4'd4) return 1;
      if (a[3:0] == 4'd8) return 2;
      return 5;
    end
    if (a[3:0] == 4'd0) return 3;
    if (a[3:0] == 4'd4) return 4;
    return 5;
  endfunction

  function automatic logic armed(input logic [31:0] c);
    return c[24] && ((c[10:9] != 2'd0) || c[28]);
  endfunction

  function automatic logic [1:0] rep_mode(input logic [31:0] c);
    return (c[10:9] == 2'd3) ? 2'd1 : c[10:9];
  endfunction

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input string req);
    int k;
    int ch;
    logic [31:0] nc;
    logic exp_start;
    k  = kind_of(a);
    ch = int'(a[6:4]);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    exp_start = 1'b0;
    if (k <= 2) begin
      if (k == 0) m_base[ch] = {8'h00, d[23:0]};
      if (k == 1) m_blk[ch]  = d;
      if (k == 2) m_ctl[ch]  = d & 32'h1177_0703;
      nc = m_ctl[ch];
      exp_start = armed(nc);
    end
    if (k == 3) m_gctl = d;
    check({req, " start"}, 32'(start_o), 32'(exp_start));
    if (exp_start) begin
      check({req, " start chan"}, 32'(start_chan_o), 32'(ch));
      check({req, " start mode R9"}, 32'(start_mode_o), 32'(rep_mode(nc)));
    end
    check({req, " err R10"}, 32'(err_o), 32'(k == 5));
    check({req, " irq strobe R6"}, 32'(irq_wr_o), 32'(k == 4));
    if (k == 4) check({req, " irq data R6"}, irq_wdata_o, d);
  endtask

  task automatic rd(input logic [6:0] a, input string req);
    int k;
    int ch;
    logic [31:0] e;
    k  = kind_of(a);
    ch = int'(a[6:4]);
    @(negedge clk);
    rd_en_i = 1'b1; addr_i = a; irq_rd_i = $urandom;
    case (k)
      0: e = m_base[ch];
      1: e = m_blk[ch];
      2: e = m_ctl[ch];
      3: e = m_gctl;
      4: e = irq_rd_i;
      default: e = 32'h0;
    endcase
    @(negedge clk);
    rd_en_i = 1'b0;
    check({req, " rdata"}, rdata_o, e);
    check({req, " err R10"}, 32'(err_o), 32'(k == 5));
    check({req, " start idle"}, 32'(start_o), 32'h0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      m_base[i] = '0; m_blk[i] = '0; m_ctl[i] = '0;
    end
    m_gctl = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 start after reset", 32'(start_o), 32'h0);
    check("R11 err after reset", 32'(err_o), 32'h0);
    for (int c = 0; c < NCH; c++) begin
      rd({c[2:0], 4'd0}, "R11 base zero");
      rd({c[2:0], 4'd8}, "R11 ctrl zero");
    end
    rd(7'h70, "R11 gctl zero");

    // R1 per-channel independence
    for (int c = 0; c < NCH; c++) wr({c[2:0], 4'd0}, 32'h0010_0000 + 32'(c), "R1 base");
    for (int c = 0; c < NCH; c++) rd({c[2:0], 4'd0}, "R1 base readback");

    wr(7'h10, 32'hFFFF_FFFF, "R2 base mask");
    rd(7'h10, "R2 base readback");
    wr(7'h14, 32'hABCD_1234, "R3 block");
    rd(7'h14, "R3 block readback");

    wr(7'h38, 32'hFFFF_FFFF, "R4 ctrl all ones mode3 R9");
    rd(7'h38, "R4 ctrl mask");
    wr(7'h38, 32'h0, "R7 disable");

    wr(7'h28, 32'h0100_0000, "R8 manual no trigger");
    wr(7'h28, 32'h1100_0000, "R8 manual trigger");
    wr(7'h68, 32'h0100_0400, "R7 linked list");
    wr(7'h60, 32'h0000_4000, "R12 base write restarts");
    wr(7'h64, 32'h0002_0010, "R12 block write restarts");
    wr(7'h48, 32'h0100_0200, "R7 request");
    wr(7'h48, 32'h0000_0200, "R7 enable cleared");

    wr(7'h70, 32'hDEAD_BEEF, "R5 gctl");
    rd(7'h70, "R5 gctl readback");
    wr(7'h74, 32'h1234_5678, "R6 irq write");
    rd(7'h74, "R6 irq read");

    wr(7'h0C, 32'hFFFF_FFFF, "R10 bad chan idx");
    rd(7'h0C, "R10 bad read");
    wr(7'h78, 32'hFFFF_FFFF, "R10 bad global idx");
    rd(7'h7C, "R10 bad global read");
    rd(7'h00, "R10 no side effect");

    for (int n = 0; n < 500; n++) begin
      logic [6:0] a;
      logic [31:0] d;
      int pick;
      a[6:4] = 3'($urandom_range(0, 7));
      pick = int'($urandom_range(0, 4));
      case (pick)
        0: a[3:0] = 4'd0;
        1: a[3:0] = 4'd4;
        2: a[3:0] = 4'd8;
        3: a[3:0] = 4'($urandom);
        default: a[3:0] = 4'd8;
      endcase
      d = $urandom;
      if ($urandom_range(0, 1) == 0) wr(a, d, "R7 R8 R4 random write");
      else rd(a, "R1 R10 random read");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule